// File: doc/BRIEF.md
# I2C Master Command Queue Front End

This block sits between a register write port and a byte-level I2C bus engine. Software pushes 11-bit command words into a transmit queue. Each word describes one bus operation: write a byte or read a byte, optionally preceded by a repeated START and optionally followed by a STOP. The block presents the oldest command to the bus engine through a valid/ready handshake. It then takes the engine's per-operation result: acknowledge or no-acknowledge, arbitration lost, or a received byte. Received bytes collect in a receive queue. Software drains that queue through a read strobe.

Both queue fill levels are visible as counters. Two threshold flags serve as interrupt sources: one for a draining transmit queue and one for a filling receive queue. Every failure aborts the transfer: a no-acknowledge, lost arbitration, an illegal read after a general call, or a command written while disabled. On an abort the block flushes both queues, records a cause word, and stops issuing commands until software clears that word.

Top module: `iic_cmd_frontend`

## Requirements
- R1: A command word is decoded as: bits 7:0 write data, bit 8 read, bit 9 STOP after, bit 10 repeated START before. Commands reach `op_*` in the order they were written.
- R2: For a read command (bit 8 set), `op_wdata` is presented as 0 whatever bits 7:0 held.
- R3: `tx_level` counts queued commands. A write to a full queue (DEPTH entries) leaves the level unchanged and pulses `tx_over` for one cycle after the write.
- R4: `tx_empty_flag` is high exactly when `tx_level <= tx_thresh`. `rx_full_flag` is high exactly when `rx_level > rx_thresh`, so a threshold of 0 fires on one byte.
- R5: A successful result for an issued read pushes `res_rdata` into the receive queue. `rx_rdata` shows the oldest byte and `rx_rd` pops it. A pop from an empty queue sees `rx_rdata` = 0 and pulses `rx_under` one cycle later.
- R6: A received byte that arrives while the receive queue holds DEPTH bytes is dropped, and `rx_over` pulses one cycle later.
- R7: A no-acknowledge result sets an abort cause bit according to `res_phase` and the target configuration.
  - Phase 0 (first address byte) sets bit 1 in 10-bit mode (`tgt_cfg[12]`=1).
  - Phase 0 sets bit 4 for a general call (7-bit mode with `tgt_cfg[6:0]`=0).
  - Phase 0 otherwise sets bit 0.
  - Phase 1 (second address byte) sets bit 2.
  - Phase 2 (data) sets bit 3.
- R8: A result with `res_arb_lost` sets cause bit 12. After any abort, both levels read 0 in the next cycle and `abort_irq` is high.
- R9: While `enable` is low, `op_valid` stays low. A command written in that state is discarded and sets cause bit 11.
- R10: A read command reaching the head while the target is a general call is not issued. It sets cause bit 5 and is flushed.
- R11: While the cause word is nonzero no command is issued. A pulse on `abrt_clr` with no new abort clears the cause word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Block enable |
| tgt_cfg | input | 13 | Target address [9:0], bit 12 selects 10-bit addressing |
| tx_thresh | input | LW | Transmit-low threshold |
| rx_thresh | input | LW | Receive-high threshold |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | 11 | Command word |
| rx_rd | input | 1 | Receive pop strobe |
| rx_rdata | output | 8 | Oldest received byte, 0 when empty |
| abrt_clr | input | 1 | Clear the abort cause word |
| tx_level | output | LW | Transmit queue fill level |
| rx_level | output | LW | Receive queue fill level |
| tx_empty_flag | output | 1 | Transmit level at or below threshold |
| rx_full_flag | output | 1 | Receive level above threshold |
| tx_over | output | 1 | Transmit overflow pulse |
| rx_under | output | 1 | Receive underflow pulse |
| rx_over | output | 1 | Receive overflow pulse |
| abort_irq | output | 1 | Abort pending |
| abort_cause | output | 13 | Abort cause bits |
| op_valid | output | 1 | Operation offered to bus engine |
| op_ready | input | 1 | Bus engine accepts operation |
| op_read | output | 1 | Operation is a read |
| op_stop | output | 1 | STOP after operation |
| op_restart | output | 1 | Repeated START before operation |
| op_wdata | output | 8 | Byte to write |
| res_valid | input | 1 | Bus engine result strobe |
| res_nack | input | 1 | Operation was not acknowledged |
| res_phase | input | 2 | Byte that failed: 0 first address, 1 second address, 2 data |
| res_arb_lost | input | 1 | Arbitration was lost |
| res_rdata | input | 8 | Received byte |

## Verification
The hardest state to reach is a receive overflow. The queue must already be full of bytes that the engine really returned, which takes DEPTH complete read round trips with no pops before one more read can complete. The bench acts as the bus engine. It issues one read command at a time, returns a distinct byte for each, and keeps `rx_rd` low until the extra byte arrives. It then drains the queue to show that only the first DEPTH bytes were kept, in order. The abort cause mapping is covered by the same kind of full round trip: a queued command is issued, a no-acknowledge is returned for each phase and target mode, and further commands are written while the abort is pending.

// File: rtl/iic_cmd_frontend.sv
module iic_cmd_frontend #(
  parameter int DEPTH = 4,              // power of two
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [12:0]   tgt_cfg,
  input  logic [LW-1:0] tx_thresh,
  input  logic [LW-1:0] rx_thresh,
  input  logic          cmd_wr,
  input  logic [10:0]   cmd_wdata,
  input  logic          rx_rd,
  output logic [7:0]    rx_rdata,
  input  logic          abrt_clr,
  output logic [LW-1:0] tx_level,
  output logic [LW-1:0] rx_level,
  output logic          tx_empty_flag,
  output logic          rx_full_flag,
  output logic          tx_over,
  output logic          rx_under,
  output logic          rx_over,
  output logic          abort_irq,
  output logic [12:0]   abort_cause,
  output logic          op_valid,
  input  logic          op_ready,
  output logic          op_read,
  output logic          op_stop,
  output logic          op_restart,
  output logic [7:0]    op_wdata,
  input  logic          res_valid,
  input  logic          res_nack,
  input  logic [1:0]    res_phase,
  input  logic          res_arb_lost,
  input  logic [7:0]    res_rdata
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [10:0]   txq [DEPTH];
  logic [7:0]    rxq [DEPTH];
  logic [AW-1:0] tx_rp, tx_wp, rx_rp, rx_wp;
  logic [LW-1:0] tx_cnt, rx_cnt;
  logic [12:0]   cause, nc;
  logic          pend_rd;

  wire        tx_full  = (tx_cnt == FULL);
  wire        tx_empty = (tx_cnt == '0);
  wire        rx_full  = (rx_cnt == FULL);
  wire        rx_empty = (rx_cnt == '0);
  wire        ten      = tgt_cfg[12];
  wire        gcall    = !ten && (tgt_cfg[6:0] == 7'd0);
  wire [10:0] head     = txq[tx_rp];
  wire        can_go   = enable && !tx_empty && (cause == '0);
  wire        gc_rd    = can_go && head[8] && gcall;
  wire        issue    = op_valid && op_ready;
  wire        wr_ok    = cmd_wr && enable && !tx_full;
  wire        res_ok   = res_valid && !res_nack && !res_arb_lost;
  wire        abort    = (nc != '0);
  wire        rx_push  = res_ok && pend_rd;
  wire        rx_pop   = rx_rd && !rx_empty;

  assign op_valid      = can_go && !gc_rd;
  assign op_read       = head[8];
  assign op_stop       = head[9];
  assign op_restart    = head[10];
  assign op_wdata      = head[8] ? 8'h00 : head[7:0];
  assign rx_rdata      = rx_empty ? 8'h00 : rxq[rx_rp];
  assign tx_level      = tx_cnt;
  assign rx_level      = rx_cnt;
  assign tx_empty_flag = (tx_cnt <= tx_thresh);
  assign rx_full_flag  = (rx_cnt > rx_thresh);
  assign abort_cause   = cause;
  assign abort_irq     = (cause != '0);

  always_comb begin
    nc = '0;
    if (cmd_wr && !enable) nc[11] = 1'b1;
    if (gc_rd)             nc[5]  = 1'b1;
    if (res_valid && res_arb_lost) nc[12] = 1'b1;
    else if (res_valid && res_nack) begin
      case (res_phase)
        2'd0:    if (ten) nc[1] = 1'b1; else if (gcall) nc[4] = 1'b1; else nc[0] = 1'b1;
        2'd1:    nc[2] = 1'b1;
        default: nc[3] = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok && !abort) txq[tx_wp] <= cmd_wdata;
    if (rx_push && !rx_full && !abort) rxq[rx_wp] <= res_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_rp <= '0; tx_wp <= '0; tx_cnt <= '0;
      rx_rp <= '0; rx_wp <= '0; rx_cnt <= '0;
      cause <= '0; pend_rd <= 1'b0;
      tx_over <= 1'b0; rx_under <= 1'b0; rx_over <= 1'b0;
    end else begin
      cause    <= (abrt_clr ? 13'd0 : cause) | nc;
      tx_over  <= cmd_wr && enable && tx_full;
      rx_under <= rx_rd && rx_empty;
      rx_over  <= rx_push && rx_full;
      if (abort) begin
        tx_rp <= '0; tx_wp <= '0; tx_cnt <= '0;
        rx_rp <= '0; rx_wp <= '0; rx_cnt <= '0;
        pend_rd <= 1'b0;
      end else begin
        if (wr_ok) tx_wp <= tx_wp + 1'b1;
        if (issue) tx_rp <= tx_rp + 1'b1;
        tx_cnt <= tx_cnt + LW'(wr_ok) - LW'(issue);
        if (rx_push && !rx_full) rx_wp <= rx_wp + 1'b1;
        if (rx_pop) rx_rp <= rx_rp + 1'b1;
        rx_cnt <= rx_cnt + LW'(rx_push && !rx_full) - LW'(rx_pop);
        if (issue) pend_rd <= head[8];
        else if (res_valid) pend_rd <= 1'b0;
      end
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= FULL) && (rx_level <= FULL));
  assert_full_write_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && enable && tx_level == FULL && !op_ready && !res_valid) |=> (tx_level == FULL) && tx_over);
  assert_flush_on_arb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_arb_lost) |=> (tx_level == '0) && (rx_level == '0) && abort_cause[12]);
  assert_disabled_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !enable) |=> abort_cause[11] && (tx_level == '0));
  assert_halt_while_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    abort_irq |-> !op_valid);
  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (abrt_clr && abort_irq && !cmd_wr && !res_valid) |=> (abort_cause == '0));
endmodule

// File: tb/iic_cmd_frontend_bench.sv
module iic_cmd_frontend_bench;
  localparam int DEPTH = 4;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, enable = 0;
  logic [12:0] tgt_cfg = 13'h050;
  logic [LW-1:0] tx_thresh = '0, rx_thresh = '0;
  logic cmd_wr = 0, rx_rd = 0, abrt_clr = 0, op_ready = 0;
  logic [10:0] cmd_wdata = '0;
  logic res_valid = 0, res_nack = 0, res_arb_lost = 0;
  logic [1:0] res_phase = '0;
  logic [7:0] res_rdata = '0;
  logic [7:0] rx_rdata, op_wdata;
  logic [LW-1:0] tx_level, rx_level;
  logic tx_empty_flag, rx_full_flag, tx_over, rx_under, rx_over, abort_irq;
  logic op_valid, op_read, op_stop, op_restart;
  logic [12:0] abort_cause;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  iic_cmd_frontend #(.DEPTH(DEPTH)) u_iic_cmd_frontend (
    .clk, .rst_n, .enable, .tgt_cfg, .tx_thresh, .rx_thresh, .cmd_wr, .cmd_wdata,
    .rx_rd, .rx_rdata, .abrt_clr, .tx_level, .rx_level, .tx_empty_flag, .rx_full_flag,
    .tx_over, .rx_under, .rx_over, .abort_irq, .abort_cause, .op_valid, .op_ready,
    .op_read, .op_stop, .op_restart, .op_wdata, .res_valid, .res_nack, .res_phase,
    .res_arb_lost, .res_rdata);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic push(input logic [10:0] c);
    cmd_wr = 1; cmd_wdata = c; @(negedge clk); cmd_wr = 0;
  endtask
  task automatic issue_one();
    op_ready = 1; @(negedge clk); op_ready = 0;
  endtask
  task automatic result(input logic nack, input logic [1:0] ph, input logic arb, input logic [7:0] d);
    res_valid = 1; res_nack = nack; res_phase = ph; res_arb_lost = arb; res_rdata = d;
    @(negedge clk); res_valid = 0; res_nack = 0; res_arb_lost = 0;
  endtask
  task automatic pop();
    rx_rd = 1; @(negedge clk); rx_rd = 0;
  endtask
  task automatic clear_abort();
    abrt_clr = 1; @(negedge clk); abrt_clr = 0;
  endtask

  task automatic t_reset();
    chk(tx_level, 0, "R3 reset tx_level");
    chk(rx_level, 0, "R5 reset rx_level");
    chk(op_valid, 0, "R9 reset op_valid");
    chk(abort_cause, 0, "R11 reset cause");
    chk(tx_empty_flag, 1, "R4 reset tx_empty_flag");
    chk(rx_full_flag, 0, "R4 reset rx_full_flag");
  endtask

  task automatic t_fields();
    push(11'h4A5);
    push(11'h3FF);
    chk(tx_level, 2, "R3 level after two writes");
    chk(op_valid, 1, "R1 op_valid");
    chk(op_wdata, 8'hA5, "R1 wdata");
    chk({op_restart, op_stop, op_read}, 3'b100, "R1 flags first");
    issue_one();
    result(0, 2'd2, 0, 8'h00);
    chk(op_wdata, 8'h00, "R2 read data zeroed");
    chk({op_restart, op_stop, op_read}, 3'b011, "R1 flags second");
    issue_one();
    result(0, 2'd2, 0, 8'h5C);
    chk(rx_level, 1, "R5 rx byte stored");
    chk(rx_full_flag, 1, "R4 rx threshold 0 fires on one byte");
    chk(rx_rdata, 8'h5C, "R5 rx data");
    pop();
    chk(rx_level, 0, "R5 pop");
    rx_rd = 1;
    chk(rx_rdata, 0, "R5 empty read data");
    @(negedge clk); rx_rd = 0;
    chk(rx_under, 1, "R5 underflow pulse");
    @(negedge clk);
    chk(rx_under, 0, "R5 underflow one cycle");
  endtask

  task automatic t_thresh_overflow();
    tx_thresh = 1;
    for (int i = 1; i <= 4; i++) push(11'(i));
    chk(tx_level, 4, "R3 full level");
    chk(tx_empty_flag, 0, "R4 tx flag above thresh");
    push(11'h077);
    chk(tx_over, 1, "R3 overflow pulse");
    chk(tx_level, 4, "R3 overflow dropped");
    for (int i = 1; i <= 4; i++) begin
      chk(op_wdata, 8'(i), "R1 order");
      issue_one();
      result(0, 2'd2, 0, 8'h00);
      if (i == 3) chk(tx_empty_flag, 1, "R4 tx flag at thresh");
    end
    chk(tx_level, 0, "R3 drained");
  endtask

  task automatic t_rx_overflow();
    rx_thresh = 3;
    for (int i = 0; i < 5; i++) begin
      push(11'h100);
      issue_one();
      if (i == 4) begin
        res_valid = 1; res_rdata = 8'hE0; @(negedge clk); res_valid = 0;
        chk(rx_over, 1, "R6 overflow pulse");
      end else result(0, 2'd2, 0, 8'(8'h10 + i));
      if (i == 3) chk(rx_full_flag, 1, "R4 rx flag above thresh");
    end
    chk(rx_level, 4, "R6 level held");
    for (int i = 0; i < 4; i++) begin
      chk(rx_rdata, 8'(8'h10 + i), "R6 kept bytes in order");
      pop();
    end
  endtask

  task automatic t_nack(input logic [12:0] tgt, input logic [1:0] ph, input int bitn);
    tgt_cfg = tgt;
    push(11'h011); push(11'h022);
    issue_one();
    result(1, ph, 0, 8'h00);
    chk(abort_cause, 13'(1 << bitn), "R7 cause bit");
    chk(tx_level, 0, "R8 flush after nack");
    chk(abort_irq, 1, "R8 abort_irq");
    push(11'h033);
    chk(op_valid, 0, "R11 held while aborted");
    clear_abort();
    chk(abort_cause, 0, "R11 clear");
    chk(op_valid, 1, "R11 resumes");
    issue_one();
    result(0, 2'd2, 0, 8'h00);
    tgt_cfg = 13'h050;
  endtask

  task automatic t_arb();
    push(11'h100); issue_one(); result(0, 2'd2, 0, 8'h99);
    push(11'h044); issue_one();
    chk(rx_level, 1, "R8 rx byte before abort");
    result(0, 2'd2, 1, 8'h00);
    chk(abort_cause, 13'h1000, "R8 arb lost bit 12");
    chk(rx_level, 0, "R8 rx flushed");
    clear_abort();
  endtask

  task automatic t_gcall();
    tgt_cfg = 13'h000;
    push(11'h100);
    chk(op_valid, 0, "R10 gcall read not issued");
    @(negedge clk);
    chk(abort_cause, 13'h0020, "R10 cause bit 5");
    chk(tx_level, 0, "R10 flushed");
    clear_abort();
    tgt_cfg = 13'h050;
  endtask

  task automatic t_disabled();
    enable = 0;
    push(11'h0AA);
    chk(abort_cause, 13'h0800, "R9 cause bit 11");
    chk(tx_level, 0, "R9 write dropped");
    chk(op_valid, 0, "R9 no issue while disabled");
    clear_abort();
    enable = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1; enable = 1;
    @(negedge clk);
    t_fields();
    t_thresh_overflow();
    t_rx_overflow();
    t_nack(13'h050, 2'd0, 0);
    t_nack(13'h1050, 2'd0, 1);
    t_nack(13'h1050, 2'd1, 2);
    t_nack(13'h050, 2'd2, 3);
    t_nack(13'h000, 2'd0, 4);
    t_arb();
    t_gcall();
    t_disabled();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule